// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores incoming frames into a ring of receive descriptors that live in host memory. A frame arrives as a byte stream with a last-byte marker. The block looks for a slot the host has handed over, copies the bytes into that slot's buffer and writes the byte count into the descriptor. It then writes a completion status that returns the slot to the host and pulses a receive event. While idle it sweeps the descriptor status bytes so that it can tell its neighbours whether any slot is free.

Memory is reached through one byte-wide synchronous port. A read issued in one cycle returns its data in the next cycle. Descriptor `i` starts at `ring_base + 8*i`. The slot buffers follow the descriptor table back to back, so buffer `i` starts at `ring_base + 8*RING + i*SLOT_BYTES`.

The controller is written as one state machine. In `ST_IDLE` it waits. A pending frame leads to `ST_SRCH_RD` when running, or to `ST_DRAIN` when stopped. With no frame pending and the block running, it leads to `ST_POLL_RD`. `ST_POLL_RD` and `ST_POLL_CHK` read one status byte for the ownership sweep and then return to `ST_IDLE`. `ST_SRCH_RD` and `ST_SRCH_CHK` read and test one candidate status. A hit goes to `ST_COPY`. A miss moves to the next candidate through `ST_SRCH_RD`, or goes to `ST_DRAIN` once the last candidate has failed. `ST_COPY` accepts bytes until the last byte, then goes to `ST_LEN_LO`. `ST_LEN_LO`, `ST_LEN_HI` and `ST_MARK` each take one cycle and run in that order, and `ST_MARK` returns to `ST_IDLE`. `ST_DRAIN` consumes bytes without storing them until the last byte, then returns to `ST_IDLE`.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring has 2**N_LOG entries (16 by default). The receive pointer wraps from the last entry back to entry 0.
- R2: A descriptor is usable only when its status byte (offset 2) is exactly 0x80. A status such as 0x81 or 0xC0 is skipped and left unchanged.
- R3: The search starts at the receive pointer and examines RING-1 consecutive entries, so the entry just before the pointer is never taken. The first usable entry is chosen, and after the store the pointer becomes that entry plus one.
- R4: Frame byte k is written to byte `ring_base + 8*RING + slot*SLOT_BYTES + k`.
- R5: The stored byte count is written byte-swapped into the length field. The low byte goes to descriptor offset 6 and the high byte to offset 7.
- R6: After the data and the length, the status byte of the chosen descriptor is written as 0x03 (start and end set, owner bit clear).
- R7: `rx_event` pulses for one cycle per stored frame. `rx_irq` pulses in the same cycle only when `irq_en` is high.
- R8: A frame that arrives while `stopped` is high is fully consumed with no memory read or write, no `rx_event` and no `rx_miss`.
- R9: When no usable entry is found, `rx_miss` pulses once, the frame is consumed and nothing is written to memory.
- R10: Bytes beyond SLOT_BYTES are consumed but not written, and the stored count saturates at SLOT_BYTES.
- R11: After a full idle sweep, `can_rx` is high if any of the RING status bytes equals 0x80. `can_rx` drops as soon as `stopped` is high.
- R12: After reset, `can_rx` and `in_ready` are low and the receive pointer is entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of descriptor 0 |
| stopped | input | 1 | Controller halted; frames are dropped |
| irq_en | input | 1 | Enables the interrupt pulse |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Byte is consumed at this edge when valid |
| mem_re | output | 1 | Memory read request; data returns next cycle |
| mem_we | output | 1 | Memory byte write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| can_rx | output | 1 | A usable slot was seen in the last sweep and the controller is running |
| rx_event | output | 1 | One-cycle pulse when a frame is stored |
| rx_irq | output | 1 | Interrupt pulse when a frame is stored and enabled |
| rx_miss | output | 1 | One-cycle pulse when a frame finds no slot |

## Verification
The bench builds the block with N_LOG=2 and SLOT_BYTES=8, so the ring has four entries and each buffer holds eight bytes. With a four-entry ring, a pointer wrap takes only a handful of frames. It also makes the excluded entry before the pointer easy to isolate. The eight-byte slot lets short frames reach and pass the truncation limit.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_RD,
        ST_POLL_CHK,
        ST_SRCH_RD,
        ST_SRCH_CHK,
        ST_COPY,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_MARK,
        ST_DRAIN
    } rxr_state_e;

    localparam logic [7:0] OWN_ONLY   = 8'h80;
    localparam logic [7:0] DONE_CODE  = 8'h03;
    localparam int         DESC_BYTES = 8;
    localparam int         STAT_OFS   = 2;
    localparam int         LEN_OFS    = 6;
    localparam int         CNT_W      = 16;

endpackage

// File: rtl/rxr_addr.sv
module rxr_addr #(
    parameter int N_LOG      = 4,
    parameter int SLOT_BYTES = 1544,
    parameter int ADDR_W     = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [N_LOG-1:0]  desc_idx,
    input  logic [N_LOG-1:0]  buf_idx,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [ADDR_W-1:0] buf_start
);
    import rxr_pkg::*;

    localparam int RING      = 1 << N_LOG;
    localparam int TABLE_LEN = RING * DESC_BYTES;

    assign desc_addr = base + ADDR_W'(desc_idx) * ADDR_W'(DESC_BYTES);
    assign buf_start = base + ADDR_W'(TABLE_LEN)
                     + ADDR_W'(buf_idx) * ADDR_W'(SLOT_BYTES);

endmodule

// File: rtl/rxr_poll.sv
module rxr_poll #(
    parameter int N_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             owned,
    output logic [N_LOG-1:0] idx,
    output logic             any_q
);
    localparam int RING = 1 << N_LOG;

    logic acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            acc   <= 1'b0;
            any_q <= 1'b0;
        end else if (step) begin
            if (idx == N_LOG'(RING - 1)) begin
                any_q <= acc | owned;
                acc   <= 1'b0;
                idx   <= '0;
            end else begin
                acc   <= acc | owned;
                idx   <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int N_LOG      = 4,
    parameter int SLOT_BYTES = 1544,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic              stopped,
    input  logic              irq_en,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              can_rx,
    output logic              rx_event,
    output logic              rx_irq,
    output logic              rx_miss
);
    import rxr_pkg::*;

    localparam int RING = 1 << N_LOG;
    localparam logic [N_LOG-1:0] LAST_TRY = N_LOG'(RING - 2);
    localparam logic [CNT_W-1:0] SLOT_CAP = CNT_W'(SLOT_BYTES);

    rxr_state_e        st, st_nx;
    logic [N_LOG-1:0]  ptr, srch_idx, tries, poll_idx, desc_sel;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] desc_addr, buf_start;
    logic              hit, last_try, poll_any, room;

    assign hit      = (mem_rdata == OWN_ONLY);
    assign last_try = (tries == LAST_TRY);
    assign room     = (cnt < SLOT_CAP);
    assign desc_sel = (st == ST_POLL_RD) ? poll_idx : srch_idx;
    assign can_rx   = poll_any & ~stopped;

    rxr_addr #(.N_LOG(N_LOG), .SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W)) i_addr (
        .base      (ring_base),
        .desc_idx  (desc_sel),
        .buf_idx   (srch_idx),
        .desc_addr (desc_addr),
        .buf_start (buf_start)
    );

    rxr_poll #(.N_LOG(N_LOG)) i_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (st == ST_POLL_CHK),
        .owned (hit),
        .idx   (poll_idx),
        .any_q (poll_any)
    );

    // next-state selection
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (in_valid)      st_nx = stopped ? ST_DRAIN : ST_SRCH_RD;
                else if (!stopped) st_nx = ST_POLL_RD;
            end
            ST_POLL_RD:  st_nx = ST_POLL_CHK;
            ST_POLL_CHK: st_nx = ST_IDLE;
            ST_SRCH_RD:  st_nx = ST_SRCH_CHK;
            ST_SRCH_CHK: begin
                if (hit)           st_nx = ST_COPY;
                else if (last_try) st_nx = ST_DRAIN;
                else               st_nx = ST_SRCH_RD;
            end
            ST_COPY:   if (in_valid && in_last) st_nx = ST_LEN_LO;
            ST_LEN_LO: st_nx = ST_LEN_HI;
            ST_LEN_HI: st_nx = ST_MARK;
            ST_MARK:   st_nx = ST_IDLE;
            ST_DRAIN:  if (in_valid && in_last) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ptr      <= '0;
            srch_idx <= '0;
            tries    <= '0;
            cnt      <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && in_valid && !stopped) begin
                srch_idx <= ptr;
                tries    <= '0;
                cnt      <= '0;
            end
            if (st == ST_SRCH_CHK && !hit && !last_try) begin
                srch_idx <= srch_idx + 1'b1;
                tries    <= tries + 1'b1;
            end
            if (st == ST_COPY && in_valid && room)
                cnt <= cnt + 1'b1;
            if (st == ST_MARK)
                ptr <= srch_idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_event  = 1'b0;
        rx_irq    = 1'b0;
        rx_miss   = 1'b0;
        unique case (st)
            ST_POLL_RD, ST_SRCH_RD: begin
                mem_re   = 1'b1;
                mem_addr = desc_addr + ADDR_W'(STAT_OFS);
            end
            ST_SRCH_CHK: rx_miss = !hit && last_try;
            ST_COPY: begin
                in_ready  = 1'b1;
                mem_we    = in_valid && room;
                mem_addr  = buf_start + ADDR_W'(cnt);
                mem_wdata = in_data;
            end
            ST_LEN_LO: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(LEN_OFS);
                mem_wdata = cnt[7:0];
            end
            ST_LEN_HI: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(LEN_OFS + 1);
                mem_wdata = cnt[15:8];
            end
            ST_MARK: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(STAT_OFS);
                mem_wdata = DONE_CODE;
                rx_event  = 1'b1;
                rx_irq    = irq_en;
            end
            ST_DRAIN: in_ready = 1'b1;
            default: ;
        endcase
    end

    // R4: a data write stays inside the chosen slot's buffer
    p_copy_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COPY && mem_we) |->
            (mem_addr >= buf_start && mem_addr < buf_start + ADDR_W'(SLOT_BYTES)));

    // R3: pointer moves to the entry after the stored one
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> (ptr == N_LOG'($past(srch_idx) + 1'b1)));

    // R6: status is released only right after both length bytes
    p_mark_after_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> ($past(st) == ST_LEN_HI));

    // R8: dropping a frame never touches memory
    p_drain_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN) |-> (!mem_we && !mem_re));

    // R10: stored count never exceeds the slot size
    p_len_capped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LEN_LO) |-> (cnt <= SLOT_CAP));

    // R2: copying only begins after a status of exactly the owner bit
    p_copy_needs_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SRCH_CHK && st_nx == ST_COPY) |=> ($past(mem_rdata) == OWN_ONLY));

endmodule

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;

    localparam int N_LOG = 2;
    localparam int SLOT  = 8;
    localparam int AW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stopped = 1'b0, irq_en = 1'b0;
    logic          in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready, mem_re, mem_we, can_rx, rx_event, rx_irq, rx_miss;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;
    logic [7:0]    mem [0:255];

    int n_chk = 0, n_bad = 0;
    int ev_cnt = 0, miss_cnt = 0, irq_cnt = 0, wr_cnt = 0, rd_cnt = 0;

    always #10 clk = ~clk;

    rx_ring_writer #(.N_LOG(N_LOG), .SLOT_BYTES(SLOT), .ADDR_W(AW)) i_rx_ring_writer (
        .clk(clk), .rst_n(rst_n), .ring_base(16'h0000), .stopped(stopped),
        .irq_en(irq_en), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .can_rx(can_rx),
        .rx_event(rx_event), .rx_irq(rx_irq), .rx_miss(rx_miss)
    );

    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_cnt++;
        end
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt++;
        end
        if (rx_event) ev_cnt++;
        if (rx_miss)  miss_cnt++;
        if (rx_irq)   irq_cnt++;
    end

    // {owned mask[3:0], frame length, expected slot (7 = miss)}
    localparam logic [14:0] VEC [6] = '{
        {4'b0001, 8'd3,  3'd0},
        {4'b0100, 8'd5,  3'd2},
        {4'b0010, 8'd8,  3'd1},
        {4'b1000, 8'd2,  3'd7},
        {4'b0110, 8'd12, 3'd1},
        {4'b0000, 8'd4,  3'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; stopped = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_data  = seed + 8'(k);
            in_last  = (k == len - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e0, m0, w0, r0, i0, bad_bytes, stored;
        logic [3:0] mask;
        int len, slot;
        logic [7:0] seed;

        // R12: reset state
        do_reset();
        #1;
        chk("R12 can_rx after reset", int'(can_rx), 0);
        chk("R12 in_ready after reset", int'(in_ready), 0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            mask = VEC[v][14:11];
            len  = int'(VEC[v][10:3]);
            slot = int'(VEC[v][2:0]);
            seed = 8'h11 + 8'(v * 16);
            do_reset();
            for (int i = 0; i < 4; i++) mem[8*i+2] = mask[i] ? 8'h80 : 8'h00;
            e0 = ev_cnt; m0 = miss_cnt; w0 = wr_cnt; i0 = irq_cnt;
            send_frame(len, seed);
            if (slot < 4) begin
                stored = (len > SLOT) ? SLOT : len;
                chk("R6 status written 0x03", int'(mem[8*slot+2]), 3);
                chk("R5 length low byte", int'(mem[8*slot+6]), stored);
                chk("R5 length high byte", int'(mem[8*slot+7]), 0);
                bad_bytes = 0;
                for (int k = 0; k < stored; k++)
                    if (mem[32+8*slot+k] !== seed + 8'(k)) bad_bytes++;
                chk("R4 buffer contents", bad_bytes, 0);
                chk("R10 byte past stored count untouched", int'(mem[32+8*slot+stored]), 0);
                chk("R7 one rx_event", ev_cnt - e0, 1);
                chk("R7 no irq when disabled", irq_cnt - i0, 0);
            end else begin
                chk("R9 one miss pulse", miss_cnt - m0, 1);
                chk("R9 no event", ev_cnt - e0, 0);
                chk("R9 no writes", wr_cnt - w0, 0);
                for (int i = 0; i < 4; i++)
                    chk("R9 status unchanged", int'(mem[8*i+2]), mask[i] ? 128 : 0);
            end
        end

        // R2: near-miss status values are skipped and left alone
        do_reset();
        mem[2] = 8'h81; mem[10] = 8'hC0; mem[18] = 8'h80;
        send_frame(2, 8'h40);
        chk("R2 0x81 untouched", int'(mem[2]), 8'h81);
        chk("R2 0xC0 untouched", int'(mem[10]), 8'hC0);
        chk("R2 exact owner slot used", int'(mem[18]), 3);

        // R1 and R3: pointer advance and wrap
        do_reset();
        for (int i = 0; i < 4; i++) mem[8*i+2] = 8'h80;
        for (int f = 0; f < 4; f++) begin
            send_frame(2, 8'h50 + 8'(f));
            chk("R3 slot taken in order", int'(mem[8*f+2]), 3);
            chk("R3 stored first byte", int'(mem[32+8*f]), 8'h50 + f);
            if (f < 3) chk("R3 next slot still owned", int'(mem[8*(f+1)+2]), 8'h80);
        end
        mem[2] = 8'h80;
        send_frame(1, 8'h77);
        chk("R1 pointer wrapped to slot 0", int'(mem[2]), 3);
        chk("R1 slot 0 rewritten", int'(mem[32]), 8'h77);

        // R7: interrupt pulse with enable
        do_reset();
        irq_en = 1'b1;
        mem[2] = 8'h80;
        i0 = irq_cnt;
        send_frame(3, 8'h60);
        chk("R7 irq pulse when enabled", irq_cnt - i0, 1);
        irq_en = 1'b0;

        // R11: can_rx from sweep, and the excluded entry before the pointer
        do_reset();
        repeat (20) @(negedge clk);
        #1;
        chk("R11 can_rx low with no owned slot", int'(can_rx), 0);
        mem[26] = 8'h80;
        repeat (20) @(negedge clk);
        #1;
        chk("R11 can_rx high with owned slot", int'(can_rx), 1);
        stopped = 1'b1;
        #1;
        chk("R11 can_rx low while stopped", int'(can_rx), 0);
        stopped = 1'b0;
        m0 = miss_cnt;
        send_frame(2, 8'h70);
        chk("R3 entry before pointer not searched", miss_cnt - m0, 1);
        chk("R3 entry before pointer still owned", int'(mem[26]), 8'h80);

        // R8: stopped drops frame without memory traffic
        do_reset();
        mem[2] = 8'h80;
        stopped = 1'b1;
        repeat (4) @(negedge clk);
        e0 = ev_cnt; m0 = miss_cnt; w0 = wr_cnt; r0 = rd_cnt;
        send_frame(3, 8'h90);
        chk("R8 no reads while stopped", rd_cnt - r0, 0);
        chk("R8 no writes while stopped", wr_cnt - w0, 0);
        chk("R8 no event while stopped", ev_cnt - e0, 0);
        chk("R8 no miss while stopped", miss_cnt - m0, 0);
        chk("R8 status untouched", int'(mem[2]), 8'h80);
        stopped = 1'b0;

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule